// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM of 2048 x 8. The host raises a single request with a direction, an 11-bit address and, for writes, a data byte. The controller turns that request into one complete bus cycle on the memory pins: chip enable, write enable and output enable (all active low), a registered address, and a data bus split into an output value, an input value and a drive enable for the pad.

Every interval of the memory cycle is a whole number of clock cycles set by a parameter: read access, write-enable pulse width, data setup before the write window closes, data hold after it closes, and write recovery. The defaults suit a 100 ns memory grade at a 50 MHz clock. The write window is the overlap of chip enable and write enable. Output enable stays high for the whole write, and the controller drives the data bus only inside the window, turning its drivers on one cycle after write enable has fallen.

Read data is sampled into a register on the clock edge at which the access count runs out, and a one-cycle done pulse follows. The busy flag covers the whole cycle, recovery included, and new requests are taken only while idle.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy and done are 0, chip enable, write enable and output enable are all 1, and the data drive enable is 0.
- R2: A read (req_write = 0) holds chip enable and output enable at 0 and write enable at 1 for exactly ACC_CYC cycles with the request address on the pins; busy is high for exactly those ACC_CYC cycles.
- R3: A write holds write enable at 0 for exactly WP_CYC consecutive cycles, chip enable is 0 whenever write enable is 0, and output enable stays at 1 through the whole write.
- R4: During a write, chip enable falls one cycle before write enable and the address on the pins equals the request address and stays constant from that cycle until chip enable rises again.
- R5: The data drive enable is 1 only while chip enable is 0 and output enable is 1; inside the write-enable pulse it is 1 for exactly WP_CYC-1 cycles (never in the first pulse cycle), which is at least DS_CYC, and the driven value equals the request data.
- R6: After write enable rises, chip enable stays 0 and the data stays driven for exactly HOLD_CYC cycles.
- R7: After the hold phase all strobes are 1 and the drivers are off for exactly RECOV_CYC cycles while busy stays high, so a write keeps busy high for 1 + WP_CYC + HOLD_CYC + RECOV_CYC cycles.
- R8: A request raised while busy is ignored: the ongoing cycle keeps its own address and data, and no further cycle starts after it ends.
- R9: done is high for exactly one cycle, the first cycle with busy low after a cycle ends, for reads and writes alike.
- R10: rd_data holds the bus value captured at the last access cycle of a read and keeps it unchanged through later writes until the next read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address of the request |
| req_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | A memory cycle, recovery included, is in progress |
| done | output | 1 | One-cycle pulse when a cycle has ended |
| rd_data | output | 8 | Last captured read byte |
| sram_addr | output | 11 | Address pins of the memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Value to drive onto the data bus |
| sram_dq_in | input | 8 | Value seen on the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus pads |

## Verification
The embedded properties take for granted that reset is held low for at least one clock edge and that request inputs change only away from the rising edge; the data bus input is treated as free and never constrained. The bench drives every request at the falling edge, lets the memory model answer with the inverse of the stored byte until the access count has run out, so an early capture shows up as a wrong value, and injects stray requests in mid-cycle only as single-cycle pulses so the ignored-request rule is exercised without leaving a request pending at the end of the cycle.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ACC   = 3'd1,
      ST_WR_SETUP = 3'd2,
      ST_WR_PULSE = 3'd3,
      ST_WR_HOLD  = 3'd4,
      ST_WR_RECOV = 3'd5
   } cyc_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
   import sram_cyc_pkg::*;
#(
   parameter int ACC_CYC   = 5,
   parameter int WP_CYC    = 4,
   parameter int HOLD_CYC  = 1,
   parameter int RECOV_CYC = 1,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_zero,
   output cyc_state_e       state,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture,
   output logic             done,
   output logic             pulse_seen
);

   localparam bit              HAS_HOLD  = (HOLD_CYC > 0);
   localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD    = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HAS_HOLD ? HOLD_CYC - 1 : 0);
   localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

   cyc_state_e state_q, state_d;
   logic       finish;
   logic       done_q;
   logic       seen_q;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      finish   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_SETUP;
               end else begin
                  state_d  = ST_RD_ACC;
                  tmr_load = 1'b1;
                  tmr_val  = ACC_LD;
               end
            end
         end
         ST_RD_ACC: begin
            if (tmr_zero) begin
               capture = 1'b1;
               finish  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_WR_SETUP: begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = WP_LD;
         end
         ST_WR_PULSE: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (HAS_HOLD) begin
                  state_d = ST_WR_HOLD;
                  tmr_val = HOLD_LD;
               end else begin
                  state_d = ST_WR_RECOV;
                  tmr_val = RECOV_LD;
               end
            end
         end
         ST_WR_HOLD: begin
            if (tmr_zero) begin
               state_d  = ST_WR_RECOV;
               tmr_load = 1'b1;
               tmr_val  = RECOV_LD;
            end
         end
         ST_WR_RECOV: begin
            if (tmr_zero) begin
               finish  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         seen_q  <= (state_q == ST_WR_PULSE);
      end
   end

   assign state      = state_q;
   assign done       = done_q;
   assign pulse_seen = seen_q;

   // R9: the done pulse never lasts two cycles
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R8: a new cycle starts only from idle
   a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> !accept);

endmodule

// File: rtl/sram_cyc_datapath.sv
module sram_cyc_datapath #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (capture) rdata_q <= dq_in;
   end

   assign addr  = addr_q;
   assign wdata = wdata_q;
   assign rdata = rdata_q;

   // R10: the read register moves only on a capture edge
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rdata_q));

endmodule

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl
   import sram_cyc_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int ACC_CYC   = 5,
   parameter int WP_CYC    = 4,
   parameter int DS_CYC    = 2,
   parameter int HOLD_CYC  = 1,
   parameter int RECOV_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_out,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic              sram_dq_oe
);

   localparam int unsigned MAX_CYC =
      max2(max2(ACC_CYC, WP_CYC), max2(HOLD_CYC, RECOV_CYC));
   localparam int CNT_W = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_cyc_ctrl: address and data widths must be positive");
      end
      if (ACC_CYC < 1 || RECOV_CYC < 1 || HOLD_CYC < 0) begin : g_bad_count
         $error("sram_cyc_ctrl: access and recovery need at least one cycle");
      end
      if (DS_CYC < 1 || WP_CYC < DS_CYC + 1) begin : g_bad_setup
         $error("sram_cyc_ctrl: pulse must cover one turn-on cycle plus data setup");
      end
   endgenerate

   cyc_state_e       state;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             accept;
   logic             capture;
   logic             pulse_seen;

   sram_cyc_fsm #(
      .ACC_CYC   (ACC_CYC),
      .WP_CYC    (WP_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .RECOV_CYC (RECOV_CYC),
      .CNT_W     (CNT_W)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .tmr_zero   (tmr_zero),
      .state      (state),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .accept     (accept),
      .capture    (capture),
      .done       (done),
      .pulse_seen (pulse_seen)
   );

   sram_cyc_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sram_cyc_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) dp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (sram_dq_in),
      .addr      (sram_addr),
      .wdata     (sram_dq_out),
      .rdata     (rd_data)
   );

   assign busy       = (state != ST_IDLE);
   assign sram_ce_n  = !(state inside {ST_RD_ACC, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
   assign sram_we_n  = (state != ST_WR_PULSE);
   assign sram_oe_n  = (state != ST_RD_ACC);
   assign sram_dq_oe = ((state == ST_WR_PULSE) && pulse_seen) || (state == ST_WR_HOLD);

   // R3: write enable only inside chip enable, with output enable off
   a_r3_we_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_ce_n && sram_oe_n));

   // R2: output enable only for a read with chip enable active
   a_r2_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (!sram_ce_n && sram_we_n && !sram_dq_oe));

   // R4: address frozen while the write window is open
   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> $stable(sram_addr));

   // R4: address frozen between consecutive busy cycles
   a_r4_addr_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sram_addr));

   // R5: drivers on only with chip enable low and output enable high
   a_r5_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (!sram_ce_n && sram_oe_n));

   // R5: driven value constant while the drivers stay on
   a_r5_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

   // R5: drivers never turn on in the cycle write enable falls
   a_r5_late_on: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> !sram_dq_oe);

   // R9: done only while idle
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/sram_cyc_ctrl_tb_top.sv
module sram_cyc_ctrl_tb_top;

   localparam int ACC  = 5;
   localparam int WP   = 4;
   localparam int DS   = 2;
   localparam int HOLD = 1;
   localparam int REC  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [10:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        busy, done;
   logic [7:0]  rd_data;
   logic [10:0] sram_addr;
   logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [7:0]  sram_dq_out, sram_dq_in;

   int errors = 0;
   int checks = 0;

   logic [7:0] mem    [2048];
   logic [7:0] shadow [2048];
   int         acc_cnt = 0;
   logic [7:0] last_rd = '0;

   always #10 clk = ~clk;

   sram_cyc_ctrl #(
      .ACC_CYC (ACC), .WP_CYC (WP), .DS_CYC (DS), .HOLD_CYC (HOLD), .RECOV_CYC (REC)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .busy (busy), .done (done),
      .rd_data (rd_data), .sram_addr (sram_addr), .sram_ce_n (sram_ce_n),
      .sram_we_n (sram_we_n), .sram_oe_n (sram_oe_n), .sram_dq_out (sram_dq_out),
      .sram_dq_in (sram_dq_in), .sram_dq_oe (sram_dq_oe)
   );

   // memory model: stores while the window is open, reads valid after the access count
   always @(posedge clk) begin
      if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr] <= sram_dq_out;
      if (!sram_ce_n && !sram_oe_n) acc_cnt <= acc_cnt + 1;
      else                          acc_cnt <= 0;
   end
   assign sram_dq_in = (!sram_ce_n && !sram_oe_n && acc_cnt >= ACC - 1) ?
                       mem[sram_addr] : ~mem[sram_addr];

   function automatic int exp_wr_busy();
      return 1 + WP + HOLD + REC;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input logic [10:0] a, input logic [7:0] d,
                        input bit inject);
      int  busy_c = 0, we_c = 0, drv_we = 0, hold_c = 0, rec_c = 0, oe_c = 0;
      int  addr_bad = 0, oe_in_wr = 0, dq_bad = 0, ce_before = 0;
      bit  seen_we = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      while (busy && busy_c < 1000) begin
         busy_c++;
         if (!sram_we_n) begin
            we_c++;
            if (sram_dq_oe) drv_we++;
         end
         if (!seen_we && sram_we_n && !sram_ce_n) ce_before++;
         if (sram_dq_oe && sram_dq_out != d) dq_bad++;
         if (!sram_ce_n && sram_addr != a) addr_bad++;
         if (wr && !sram_oe_n) oe_in_wr++;
         if (!sram_oe_n) oe_c++;
         if (seen_we && sram_we_n && !sram_ce_n && sram_dq_oe) hold_c++;
         if (seen_we && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe) rec_c++;
         if (!sram_we_n) seen_we = 1'b1;
         if (inject && busy_c == 2) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = 8'h5A;
         end
         if (inject && busy_c == 3) req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      if (wr) begin
         check(busy_c == exp_wr_busy(), "R7 write busy length", busy_c, exp_wr_busy());
         check(we_c == WP, "R3 write enable width", we_c, WP);
         check(oe_in_wr == 0, "R3 output enable low in write", oe_in_wr, 0);
         check(ce_before == 1, "R4 chip enable lead", ce_before, 1);
         check(drv_we == WP - 1 && drv_we >= DS, "R5 driven cycles in pulse", drv_we, WP - 1);
         check(dq_bad == 0, "R5 driven value", dq_bad, 0);
         check(hold_c == HOLD, "R6 hold cycles", hold_c, HOLD);
         check(rec_c == REC, "R7 recovery cycles", rec_c, REC);
         check(rd_data == last_rd, "R10 read register kept over write", rd_data, last_rd);
         shadow[a] = d;
      end else begin
         check(busy_c == ACC, "R2 read busy length", busy_c, ACC);
         check(oe_c == ACC, "R2 output enable width", oe_c, ACC);
         check(we_c == 0, "R2 write enable high in read", we_c, 0);
         check(rd_data == shadow[a], "R2 captured read data", rd_data, shadow[a]);
         last_rd = rd_data;
      end
      check(addr_bad == 0, "R4 address on pins", addr_bad, 0);
      check(done == 1'b1 && busy == 1'b0, "R9 done in first idle cycle", done, 1);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle only", done, 0);
      if (inject) begin
         check(busy == 1'b0 && sram_ce_n == 1'b1, "R8 stray request ignored", busy, 0);
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2048; i++) begin mem[i] = '0; shadow[i] = '0; end
      void'($urandom(32'h5EED_0123));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 reset outputs", {busy, done, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 6'b001110);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 after release", {busy, done, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 6'b001110);

      // directed corners: lowest and highest address, all-zero and all-one data
      do_op(1'b1, 11'h000, 8'hFF, 1'b0);
      do_op(1'b1, 11'h7FF, 8'h00, 1'b0);
      do_op(1'b0, 11'h000, 8'h00, 1'b0);
      do_op(1'b0, 11'h7FF, 8'h00, 1'b0);
      do_op(1'b1, 11'h7FF, 8'hA5, 1'b0);
      do_op(1'b0, 11'h7FF, 8'h00, 1'b0);
      // R8: stray write request during a write and during a read
      do_op(1'b1, 11'h155, 8'h3C, 1'b1);
      do_op(1'b0, 11'h2AA, 8'h00, 1'b0);
      do_op(1'b0, 11'h155, 8'h00, 1'b1);
      do_op(1'b0, 11'h2AA, 8'h00, 1'b0);
      // random mix over a small address window to force re-reads
      for (int k = 0; k < 80; k++) begin
         logic [10:0] ra;
         logic [7:0]  rd;
         bit          rw;
         ra = 11'($urandom_range(0, 31)) | ((k % 2 == 0) ? 11'h000 : 11'h7E0);
         rd = 8'($urandom);
         rw = ($urandom_range(0, 1) == 1);
         do_op(rw, ra, rd, (k % 9 == 4));
         if (($urandom_range(0, 3)) == 0) @(negedge clk);
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule